// File: doc/BRIEF.md
# Multi-Mode Reloadable Timer Channel

This block is a single 16-bit timer channel. Software controls it over a byte-wide register bus. It has three operating modes, chosen by a two-bit field.

- **Timer mode:** the counter decrements on one of four clock-enable strobes, which come from an external prescaler.
- **Event mode:** the counter decrements on selected edges of an external input, or on underflow pulses from a neighbouring channel.
- **Measurement mode:** the counter increments from zero on the selected strobe. On each measurement edge the count moves into the reload register, where software can read it.

When a down-counting channel passes below zero, it reloads itself. It then raises a one-cycle interrupt request and a one-cycle underflow pulse. That pulse can drive another channel's cascade input, so two channels can be chained. In measurement mode, the interrupt fires on every capture. A sticky flag records a counter wrap that happens before the next measurement edge.

Software loads the 16-bit reload value one byte at a time. If the channel is stopped, each such write also presets the counter. If the channel is running, the write changes only the value used at the next reload.

Top module: `mtmr_top`

## Requirements
- R1: Mode field is control register bits [1:0]: 00 timer, 01 event, 10 measurement, 11 inhibited. In the inhibited code the counter holds its value, and the control register reads back exactly as written.
- R2: After reset the control register reads 0x00 (timer mode), the counter and reload register read 0, the channel is stopped, and irq and uf_out are low.
- R3: In timer mode the counter decrements once per cycle in which the strobe chosen by control bits [7:6] is high: 00 selects clk_en[0], 01 selects clk_en[1], 10 selects clk_en[2], 11 selects clk_en[3]. The other strobes have no effect.
- R4: In timer and event modes, a count step taken while the counter is 0 reloads it from the reload register. On the following cycle irq and uf_out are both high for exactly one cycle. Reaching 0 by itself raises neither.
- R5: In event mode with control bit 4 clear, the counter decrements on edges of ext_in. Control bits [3:2] choose the edge: 00 rising, 01 falling, 1x both. The counter shows the step within four clock cycles of the input change, and edges of the unselected kind are ignored.
- R6: In event mode with control bit 4 set, the counter decrements once per cycle in which casc_in is high, and ext_in is ignored.
- R7: In measurement mode the counter increments on the selected strobe. On a measurement edge of ext_in, the count is copied into the reload register, the counter clears to 0, and irq pulses. Control bit 2 clear measures the period (rising edges only). Control bit 2 set measures the width (both edges).
- R8: In measurement mode, a count step taken at 0xFFFF sets a sticky flag, which reads as control register bit 5. The flag is read-only, and any write to the control register clears it.
- R9: The counter changes only while the run bit (bit 0 at address 5) is set. The only exception is the load described in R10.
- R10: A write to a reload byte while the channel is stopped also loads the counter with the new reload value. The same write while the channel is running leaves the counter unchanged.
- R11: Register map:
  - Address 0 reads the counter low byte, and address 1 reads the counter high byte. Writes to addresses 0 and 1 go to the reload low and high bytes.
  - Addresses 2 and 3 read the reload low and high bytes.
  - Address 4 is the control register.
  - Address 5 is the run bit.
  - Addresses 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| clk_en | input | 4 | Prescaled count strobes (div1, div8, div32, sub-clock) |
| ext_in | input | 1 | External event / measurement input (asynchronous) |
| casc_in | input | 1 | Underflow pulse from a neighbouring channel |
| irq | output | 1 | One-cycle interrupt request |
| uf_out | output | 1 | One-cycle underflow pulse for cascading |

## Verification
A wrong count path shows up as a wrong counter byte read back right after the strobe or edge that should have moved it. Because the bench reads the counter after every small group of steps, a lost or extra step is caught within a few cycles. A wrong reload or a misplaced underflow shows up on irq and uf_out, either in the cycle right after the step taken at zero or one cycle too late. A broken edge detector or a broken measurement capture shows up as a wrong counter or reload byte four cycles after an ext_in change. A sticky flag that is lost or never cleared shows up in the control register read-back.

// File: rtl/mtmr_pkg.sv
package mtmr_pkg;

    localparam int CNT_W  = 16;
    localparam int BUS_W  = 8;
    localparam int ADDR_W = 3;
    localparam int NSRC   = 4;

    typedef enum logic [1:0] {
        MODE_TIMER = 2'b00,
        MODE_EVENT = 2'b01,
        MODE_MEAS  = 2'b10,
        MODE_INH   = 2'b11
    } mode_e;

    // control register contents without the read-only flag (bit 5)
    typedef struct packed {
        logic [1:0] clk_sel;   // bits 7:6
        logic       casc;      // bit 4
        logic [1:0] edge_sel;  // bits 3:2
        mode_e      mode;      // bits 1:0
    } ctrl_t;

    typedef struct packed {
        logic uf;
        logic cap;
        logic ovf;
    } core_evt_t;

    function automatic logic edge_pick(input logic [1:0] sel,
                                       input logic rise, input logic fall);
        case (sel)
            2'b00:   return rise;
            2'b01:   return fall;
            default: return rise | fall;
        endcase
    endfunction

    function automatic logic counts_down(input mode_e m);
        return (m == MODE_TIMER) || (m == MODE_EVENT);
    endfunction

endpackage

// File: rtl/mtmr_edge.sv
module mtmr_edge
    import mtmr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sig_in,
    input  logic [1:0] sel,
    output logic       hit_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   synced;

    assign synced = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], sig_in};
            prev_q <= synced;
        end
    end

    assign hit_o = edge_pick(sel, synced & ~prev_q, ~synced & prev_q);

endmodule

// File: rtl/mtmr_core.sv
module mtmr_core
    import mtmr_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  mode_e        mode,
    input  logic         run,
    input  logic         tick,
    input  logic         meas_edge,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] reload,
    output logic [W-1:0] cnt_q,
    output core_evt_t    evt,
    output logic         uf_q,
    output logic         irq_q
);
    logic [W-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        evt   = '0;
        if (load) begin
            cnt_d = load_val;
        end else if (run) begin
            if (counts_down(mode)) begin
                if (tick) begin
                    if (cnt_q == '0) begin
                        cnt_d  = reload;
                        evt.uf = 1'b1;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
            end else if (mode == MODE_MEAS) begin
                if (meas_edge) begin
                    evt.cap = 1'b1;
                    cnt_d   = '0;
                end else if (tick) begin
                    cnt_d   = cnt_q + 1'b1;
                    evt.ovf = &cnt_q;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            uf_q  <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            uf_q  <= evt.uf;
            irq_q <= evt.uf | evt.cap;
        end
    end

    AST_INHIBIT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_INH && !load) |=> $stable(cnt_q)); // R1

    AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!run && !load) |=> $stable(cnt_q)); // R9

    AST_UNDERFLOW_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (run && !load && counts_down(mode) && tick && cnt_q == '0)
        |=> (uf_q && irq_q && cnt_q == $past(reload))); // R4

    AST_CAPTURE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (run && !load && mode == MODE_MEAS && meas_edge)
        |=> (cnt_q == '0 && irq_q)); // R7

    AST_IRQ_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
        irq_q |-> $past(run)); // R9

endmodule

// File: rtl/mtmr_regs.sv
module mtmr_regs
    import mtmr_pkg::*;
#(
    parameter int W  = CNT_W,
    parameter int BW = BUS_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [BW-1:0] wdata,
    output logic [BW-1:0] rdata,
    input  logic [W-1:0]  cnt_q,
    input  core_evt_t     evt,
    output ctrl_t         ctrl_q,
    output logic          run_q,
    output logic [W-1:0]  reload_q,
    output logic          cnt_load,
    output logic [W-1:0]  load_val
);
    localparam int BYTES    = W / BW;
    localparam int A_RLD    = BYTES;
    localparam int A_CTRL   = 2 * BYTES;
    localparam int A_RUN    = 2 * BYTES + 1;

    logic          ovf_q;
    logic [W-1:0]  rld_d;
    logic          rld_hit;
    logic          ctrl_wr;

    assign ctrl_wr = wr && (addr == AW'(A_CTRL));

    always_comb begin
        rld_d   = evt.cap ? cnt_q : reload_q;
        rld_hit = 1'b0;
        for (int b = 0; b < BYTES; b++) begin
            if (wr && addr == AW'(b)) begin
                rld_d[b*BW +: BW] = wdata;
                rld_hit           = 1'b1;
            end
        end
    end

    assign cnt_load = rld_hit && !run_q;
    assign load_val = rld_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            reload_q <= '0;
            ctrl_q   <= '0;
            run_q    <= 1'b0;
            ovf_q    <= 1'b0;
        end else begin
            reload_q <= rld_d;
            if (ctrl_wr) begin
                ctrl_q <= ctrl_t'({wdata[7:6], wdata[4:0]});
            end
            if (wr && addr == AW'(A_RUN)) begin
                run_q <= wdata[0];
            end
            if (ctrl_wr) begin
                ovf_q <= 1'b0;
            end else if (evt.ovf) begin
                ovf_q <= 1'b1;
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int b = 0; b < BYTES; b++) begin
            if (addr == AW'(b))         rdata = cnt_q[b*BW +: BW];
            if (addr == AW'(A_RLD + b)) rdata = reload_q[b*BW +: BW];
        end
        if (addr == AW'(A_CTRL)) rdata = {ctrl_q[6:5], ovf_q, ctrl_q[4:0]};
        if (addr == AW'(A_RUN))  rdata = {{(BW-1){1'b0}}, run_q};
    end

    AST_FLAG_CLEARED: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr |=> !ovf_q); // R8

    AST_RUNNING_WRITE_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
        (rld_hit && run_q) |-> !cnt_load); // R10

endmodule

// File: rtl/mtmr_top.sv
module mtmr_top
    import mtmr_pkg::*;
#(
    parameter int W  = CNT_W,
    parameter int AW = ADDR_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bus_wr,
    input  logic [AW-1:0]   bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic [NSRC-1:0] clk_en,
    input  logic            ext_in,
    input  logic            casc_in,
    output logic            irq,
    output logic            uf_out
);
    ctrl_t        ctrl_q;
    logic         run_q;
    logic [W-1:0] reload_q;
    logic [W-1:0] cnt_q;
    logic [W-1:0] load_val;
    logic         cnt_load;
    core_evt_t    evt;
    logic [1:0]   edge_sel;
    logic         ext_hit;
    logic         tick;

    // measurement: bit 2 picks period (rising only) or width (both edges)
    assign edge_sel = (ctrl_q.mode == MODE_MEAS)
                    ? (ctrl_q.edge_sel[0] ? 2'b10 : 2'b00)
                    : ctrl_q.edge_sel;

    always_comb begin
        if (ctrl_q.mode == MODE_EVENT) begin
            tick = ctrl_q.casc ? casc_in : ext_hit;
        end else begin
            tick = clk_en[ctrl_q.clk_sel];
        end
    end

    mtmr_edge #(.SYNC_STAGES(2)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .sig_in (ext_in),
        .sel    (edge_sel),
        .hit_o  (ext_hit)
    );

    mtmr_regs #(.W(W), .BW(BUS_W), .AW(AW)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr       (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .rdata    (bus_rdata),
        .cnt_q    (cnt_q),
        .evt      (evt),
        .ctrl_q   (ctrl_q),
        .run_q    (run_q),
        .reload_q (reload_q),
        .cnt_load (cnt_load),
        .load_val (load_val)
    );

    mtmr_core #(.W(W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .mode      (ctrl_q.mode),
        .run       (run_q),
        .tick      (tick),
        .meas_edge (ext_hit),
        .load      (cnt_load),
        .load_val  (load_val),
        .reload    (reload_q),
        .cnt_q     (cnt_q),
        .evt       (evt),
        .uf_q      (uf_out),
        .irq_q     (irq)
    );

endmodule

// File: tb/test_mtmr_top.sv
module test_mtmr_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_active = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [2:0] rd_addr = '0;
    logic       rd_active = 1'b0;
    logic [2:0] bus_addr;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [3:0] clk_en = '0;
    logic       ext_in = 1'b0;
    logic       casc_in = 1'b0;
    logic       irq, uf_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    typedef struct {
        logic [2:0] a;
        logic [7:0] v;
        string      tag;
    } sb_item_t;

    sb_item_t sb_q[$];
    bit       mon_busy = 0;

    always #2 clk = ~clk;

    assign bus_addr = rd_active ? rd_addr : wr_addr;

    mtmr_top i_mtmr_top (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (wr_active),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .clk_en    (clk_en),
        .ext_in    (ext_in),
        .casc_in   (casc_in),
        .irq       (irq),
        .uf_out    (uf_out)
    );

    function automatic void check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endfunction

    // monitor: pops expected register values and compares against reads
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() != 0) begin
                sb_item_t it;
                mon_busy  = 1;
                it        = sb_q.pop_front();
                rd_addr   = it.a;
                rd_active = 1'b1;
                #1;
                check(it.tag, int'(bus_rdata), int'(it.v));
                rd_active = 1'b0;
                mon_busy  = 0;
            end
        end
    end

    task automatic expect_reg(input logic [2:0] a, input logic [7:0] v, input string tag);
        sb_item_t it;
        it.a = a; it.v = v; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
        wait (sb_q.size() == 0 && !mon_busy);
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        wr_addr   = a;
        bus_wdata = d;
        wr_active = 1'b1;
        @(negedge clk);
        wr_active = 1'b0;
    endtask

    task automatic strobe(input int idx, input int n);
        for (int k = 0; k < n; k++) begin
            clk_en[idx] = 1'b1;
            @(negedge clk);
            clk_en[idx] = 1'b0;
        end
    endtask

    task automatic set_ext(input logic v);
        ext_in = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic casc_pulse();
        casc_in = 1'b1;
        @(negedge clk);
        casc_in = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R2 reset state
        check("R2 irq", int'(irq), 0);
        check("R2 uf_out", int'(uf_out), 0);
        expect_reg(3'd4, 8'h00, "R2 ctrl");
        expect_reg(3'd0, 8'h00, "R2 cnt lo");
        expect_reg(3'd3, 8'h00, "R2 reload hi");
        expect_reg(3'd5, 8'h00, "R2 run");

        // R10 stopped write presets counter; R11 map
        wr_reg(3'd0, 8'h05);
        wr_reg(3'd1, 8'h00);
        expect_reg(3'd0, 8'h05, "R10 stopped load cnt");
        expect_reg(3'd2, 8'h05, "R11 reload lo");
        expect_reg(3'd6, 8'h00, "R11 unused addr");

        // R3 timer mode, strobe 1 selected
        wr_reg(3'd4, 8'h40);
        wr_reg(3'd5, 8'h01);
        strobe(1, 3);
        expect_reg(3'd0, 8'h02, "R3 decrement");
        strobe(0, 3);
        strobe(2, 2);
        expect_reg(3'd0, 8'h02, "R3 other strobes ignored");
        strobe(1, 2);
        check("R4 no irq at zero", int'(irq), 0);
        expect_reg(3'd0, 8'h00, "R3 reach zero");
        strobe(1, 1);
        check("R4 irq pulse", int'(irq), 1);
        check("R4 uf pulse", int'(uf_out), 1);
        @(negedge clk);
        check("R4 irq one cycle", int'(irq), 0);
        check("R4 uf one cycle", int'(uf_out), 0);
        expect_reg(3'd0, 8'h05, "R4 reload");

        // R10 running write updates reload only
        wr_reg(3'd0, 8'h10);
        expect_reg(3'd0, 8'h05, "R10 running cnt kept");
        expect_reg(3'd2, 8'h10, "R10 running reload");

        // R1 inhibited code holds
        wr_reg(3'd4, 8'h43);
        expect_reg(3'd4, 8'h43, "R1 ctrl readback");
        strobe(1, 3);
        expect_reg(3'd0, 8'h05, "R1 inhibited hold");

        // R9 stopped channel holds
        wr_reg(3'd4, 8'h40);
        wr_reg(3'd5, 8'h00);
        strobe(1, 3);
        expect_reg(3'd0, 8'h05, "R9 stopped hold");
        wr_reg(3'd5, 8'h01);

        // R5 event mode edges
        wr_reg(3'd4, 8'h01);
        set_ext(1'b1);
        expect_reg(3'd0, 8'h04, "R5 rising counted");
        set_ext(1'b0);
        expect_reg(3'd0, 8'h04, "R5 falling ignored");
        strobe(1, 2);
        expect_reg(3'd0, 8'h04, "R5 strobe ignored in event");
        wr_reg(3'd4, 8'h09);
        set_ext(1'b1);
        set_ext(1'b0);
        expect_reg(3'd0, 8'h02, "R5 both edges");
        wr_reg(3'd4, 8'h05);
        set_ext(1'b1);
        expect_reg(3'd0, 8'h02, "R5 rising ignored");
        set_ext(1'b0);
        expect_reg(3'd0, 8'h01, "R5 falling counted");

        // R6 cascade source
        wr_reg(3'd4, 8'h11);
        casc_pulse();
        expect_reg(3'd0, 8'h00, "R6 cascade step");
        set_ext(1'b1);
        set_ext(1'b0);
        expect_reg(3'd0, 8'h00, "R6 ext ignored");
        casc_pulse();
        check("R6 cascade underflow irq", int'(irq), 1);
        expect_reg(3'd0, 8'h10, "R6 cascade reload");

        // R7 period measurement
        wr_reg(3'd4, 8'h02);
        set_ext(1'b1);
        expect_reg(3'd0, 8'h00, "R7 first edge clears");
        strobe(0, 7);
        expect_reg(3'd0, 8'h07, "R7 increment");
        set_ext(1'b0);
        expect_reg(3'd0, 8'h07, "R7 period ignores fall");
        set_ext(1'b1);
        expect_reg(3'd2, 8'h07, "R7 period capture");
        expect_reg(3'd0, 8'h00, "R7 cleared after capture");
        expect_reg(3'd4, 8'h02, "R8 no flag yet");

        // R7 width measurement
        wr_reg(3'd4, 8'h06);
        set_ext(1'b0);
        strobe(0, 4);
        set_ext(1'b1);
        expect_reg(3'd2, 8'h04, "R7 width capture");
        expect_reg(3'd3, 8'h00, "R7 width capture hi");

        // R8 overflow flag
        clk_en[0] = 1'b1;
        repeat (65546) @(negedge clk);
        clk_en[0] = 1'b0;
        expect_reg(3'd4, 8'h26, "R8 flag set");
        wr_reg(3'd4, 8'h06);
        expect_reg(3'd4, 8'h06, "R8 flag cleared");

        finish_run();
    end

endmodule